// File: doc/BRIEF.md
# Storage Security Password Lock Controller

This block is the password lock of a storage device's security feature set. It receives one decoded security command at a time, together with a 16-bit control word and a password, and keeps the state that decides whether the media is reachable. That state is a user password, a master password, a security level, and three flags: security enabled, locked and frozen. Each command produces one result, either done or abort. A successful erase also produces a single-cycle request to erase the media. Moving the payload over the host bus, and the erase itself, belong to neighbouring blocks.

Commands enter on a valid/ready channel. `cmd_ready` is high only while no result is pending, and a command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. The result leaves on a second valid/ready channel, and the consumer may hold off `rsp_ready` for as long as it needs. While it does, the result stays constant and no new command is accepted, so back-pressure on the result side stalls the command side.

`rst_n` is the power-on reset and clears everything. `hard_rst` is a synchronous device hard reset. It leaves the frozen state and re-arms the lock from the stored passwords.

Top module: `sec_lock_ctrl`

## Requirements
- R1: After `rst_n` is released, `sec_enabled`, `sec_locked`, `sec_frozen`, `sec_level_max`, `rsp_valid` and `erase_req` are 0 and `cmd_ready` is 1. Both stored passwords are all zeros.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. In the next cycle `rsp_valid` is 1, with `rsp_abort` = 1 for abort and 0 for done. The result stays unchanged until the edge where `rsp_ready` is 1. `cmd_ready` is 0 while `rsp_valid` is 1.
- R3: Set password is code 1. With control bit 0 = 0 it stores the user password, sets enabled, and copies control bit 8 into `sec_level_max` (0 = high, 1 = maximum). With control bit 0 = 1 it stores only the master password. It aborts while locked or frozen.
- R4: Unlock is code 2. It clears `sec_locked` when the supplied password matches the password chosen by control bit 0. A user-password match counts only while enabled. A master-password match is refused at the maximum level.
- R5: Disable password is code 6. It uses the same matching rule as R4 and, on a match, clears enabled and locked. The master password stays stored.
- R6: Erase unit is code 4. Issued directly after an accepted erase prepare (code 3), with a matching user password (enabled) or master password at either level, it returns done, pulses `erase_req` for one cycle together with the first cycle of `rsp_valid`, and clears enabled and locked.
- R7: Erase unit aborts without `erase_req` when the command accepted just before it was not an erase prepare that completed. Any accepted command other than erase prepare cancels a pending prepare.
- R8: Freeze lock (code 5) always completes and sets `sec_frozen`. While frozen, codes 1, 2, 3, 4 and 6 abort and change nothing, and a repeated freeze completes.
- R9: A cycle with `hard_rst` = 1 clears frozen, any pending prepare and any pending result. It sets `sec_locked` to the value of `sec_enabled`, and it keeps both passwords and the level.
- R10: A password mismatch on unlock, disable or erase returns abort and leaves enabled, locked, level and frozen unchanged.
- R11: Codes 0 and 7 return abort and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hard_rst | input | 1 | Synchronous device hard reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_code | input | 3 | Command code: 1 set, 2 unlock, 3 erase prepare, 4 erase unit, 5 freeze, 6 disable |
| cmd_ctrl | input | 16 | Control word: bit 0 selects the password, bit 8 selects the level |
| cmd_pwd | input | PWD_W | Supplied password |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_abort | output | 1 | 1 = abort, 0 = done |
| erase_req | output | 1 | One-cycle media erase request |
| sec_enabled | output | 1 | A user password is set |
| sec_locked | output | 1 | Media access is locked |
| sec_frozen | output | 1 | Lock-changing commands are refused |
| sec_level_max | output | 1 | Security level is maximum |

## Verification
Each command is sent with a matching password and with a wrong one, so the match path and the abort path are told apart by the result and the flags. Unlock is tried with the user and with the master password at both levels, which separates the level rule from a plain comparison. Erase is sent cold, after an intervening command, and directly after prepare, so that only the strict ordering yields an erase request. Every lock-changing code is then repeated while frozen and again after a hard reset, which shows that freezing blocks them and that only the hard reset releases the block.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;
  typedef enum logic [2:0] {
    SC_NONE    = 3'd0,
    SC_SETPW   = 3'd1,
    SC_UNLOCK  = 3'd2,
    SC_ERPREP  = 3'd3,
    SC_ERUNIT  = 3'd4,
    SC_FREEZE  = 3'd5,
    SC_DISABLE = 3'd6,
    SC_RSVD    = 3'd7
  } sec_cmd_e;

  localparam int CTRL_W       = 16;
  localparam int CTRL_TGT_BIT = 0;   // 1 = master password
  localparam int CTRL_LVL_BIT = 8;   // 1 = maximum level
endpackage

// File: rtl/sec_pwd_cmp.sv
module sec_pwd_cmp #(
  parameter int PWD_W   = 256,
  parameter int CHUNK_W = 32
) (
  input  logic [PWD_W-1:0] given,
  input  logic [PWD_W-1:0] stored,
  output logic             match
);
  localparam int NCHUNK = PWD_W / CHUNK_W;
  logic [NCHUNK-1:0] chunk_eq;

  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    assign chunk_eq[i] = (given[i*CHUNK_W +: CHUNK_W] == stored[i*CHUNK_W +: CHUNK_W]);
  end

  assign match = &chunk_eq;
endmodule

// File: rtl/sec_rsp_slot.sv
module sec_rsp_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic load,
  input  logic abort_in,
  input  logic erase_in,
  input  logic rsp_ready,
  output logic rsp_valid,
  output logic rsp_abort,
  output logic erase_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_abort <= 1'b0;
      erase_req <= 1'b0;
    end else if (flush) begin
      rsp_valid <= 1'b0;
      rsp_abort <= 1'b0;
      erase_req <= 1'b0;
    end else begin
      erase_req <= load && erase_in;
      if (load) begin
        rsp_valid <= 1'b1;
        rsp_abort <= abort_in;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sec_lock_ctrl.sv
module sec_lock_ctrl
  import sec_lock_pkg::*;
#(
  parameter int PWD_W   = 256,
  parameter int CHUNK_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hard_rst,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [2:0]             cmd_code,
  input  logic [CTRL_W-1:0]      cmd_ctrl,
  input  logic [PWD_W-1:0]       cmd_pwd,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_abort,
  output logic                   erase_req,
  output logic                   sec_enabled,
  output logic                   sec_locked,
  output logic                   sec_frozen,
  output logic                   sec_level_max
);
  logic [PWD_W-1:0] user_pwd, master_pwd;
  logic             prepared;
  logic             user_match, master_match;
  logic             accept, sel_master, ok_auth, ok_erase_auth, cmd_ok, do_erase;
  sec_cmd_e         code;
  logic             ctrl_unused_bits;

  assign code             = sec_cmd_e'(cmd_code);
  assign sel_master       = cmd_ctrl[CTRL_TGT_BIT];
  assign ctrl_unused_bits = ^{cmd_ctrl[CTRL_W-1:CTRL_LVL_BIT+1], cmd_ctrl[CTRL_LVL_BIT-1:CTRL_TGT_BIT+1]};
  assign cmd_ready        = !rsp_valid && !hard_rst;
  assign accept           = cmd_valid && cmd_ready;

  sec_pwd_cmp #(.PWD_W(PWD_W), .CHUNK_W(CHUNK_W)) u_cmp_user (
    .given(cmd_pwd), .stored(user_pwd), .match(user_match));
  sec_pwd_cmp #(.PWD_W(PWD_W), .CHUNK_W(CHUNK_W)) u_cmp_master (
    .given(cmd_pwd), .stored(master_pwd), .match(master_match));

  // unlock and disable: master refused at maximum level
  assign ok_auth       = sel_master ? (master_match && !sec_level_max) : (sec_enabled && user_match);
  // erase: master accepted at either level
  assign ok_erase_auth = sel_master ? master_match : (sec_enabled && user_match);

  always_comb begin
    cmd_ok = 1'b0;
    unique case (code)
      SC_SETPW:   cmd_ok = !sec_frozen && !sec_locked;
      SC_UNLOCK:  cmd_ok = !sec_frozen && ok_auth;
      SC_DISABLE: cmd_ok = !sec_frozen && ok_auth;
      SC_ERPREP:  cmd_ok = !sec_frozen;
      SC_ERUNIT:  cmd_ok = !sec_frozen && prepared && ok_erase_auth;
      SC_FREEZE:  cmd_ok = 1'b1;
      default:    cmd_ok = 1'b0;
    endcase
  end

  assign do_erase = (code == SC_ERUNIT) && cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_pwd      <= '0;
      master_pwd    <= '0;
      sec_enabled   <= 1'b0;
      sec_locked    <= 1'b0;
      sec_frozen    <= 1'b0;
      sec_level_max <= 1'b0;
      prepared      <= 1'b0;
    end else if (hard_rst) begin
      sec_frozen <= 1'b0;
      prepared   <= 1'b0;
      sec_locked <= sec_enabled;
    end else if (accept) begin
      prepared <= (code == SC_ERPREP) && cmd_ok;
      if (cmd_ok) begin
        unique case (code)
          SC_SETPW: begin
            if (sel_master) begin
              master_pwd <= cmd_pwd;
            end else begin
              user_pwd      <= cmd_pwd;
              sec_enabled   <= 1'b1;
              sec_level_max <= cmd_ctrl[CTRL_LVL_BIT];
            end
          end
          SC_UNLOCK: sec_locked <= 1'b0;
          SC_DISABLE, SC_ERUNIT: begin
            sec_enabled <= 1'b0;
            sec_locked  <= 1'b0;
          end
          SC_FREEZE: sec_frozen <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  sec_rsp_slot u_rsp (
    .clk(clk), .rst_n(rst_n), .flush(hard_rst), .load(accept),
    .abort_in(!cmd_ok), .erase_in(do_erase), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .erase_req(erase_req));
endmodule

// File: rtl/sec_lock_ctrl_chk.sv
module sec_lock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hard_rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_code,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_abort,
  input logic       erase_req,
  input logic       sec_enabled,
  input logic       sec_locked,
  input logic       sec_frozen
);
  logic accept_q;
  assign accept_q = cmd_valid && cmd_ready;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !hard_rst) |=> (rsp_valid && $stable(rsp_abort))) else $error("rsp hold"); // R2
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready) else $error("busy accept"); // R2
  AST_ERASE_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (rsp_valid && !rsp_abort && !sec_enabled && !sec_locked)) else $error("erase result"); // R6
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req) else $error("erase pulse"); // R6
  AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_frozen && !hard_rst) |=> sec_frozen) else $error("frozen lost"); // R8
  AST_FROZEN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_q && sec_frozen && !hard_rst && cmd_code != 3'd5) |=> rsp_abort) else $error("frozen accepted"); // R8
  AST_LOCK_NEEDS_PWD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_locked |-> sec_enabled) else $error("locked without password"); // R9
endmodule

bind sec_lock_ctrl sec_lock_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_code(cmd_code), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_abort(rsp_abort), .erase_req(erase_req),
  .sec_enabled(sec_enabled), .sec_locked(sec_locked), .sec_frozen(sec_frozen));

// File: tb/sec_lock_ctrl_test.sv
module sec_lock_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 256;

  logic clk = 1'b0, rst_n = 1'b0, hard_rst = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [15:0] cmd_ctrl = '0;
  logic [PW-1:0] cmd_pwd = '0;
  logic cmd_ready, rsp_valid, rsp_abort, erase_req;
  logic sec_enabled, sec_locked, sec_frozen, sec_level_max;

  int n_checks = 0, n_fail = 0;
  logic got_abort, got_erase;

  localparam logic [PW-1:0] PW_A = {8{32'hA5A5_0101}};
  localparam logic [PW-1:0] PW_B = {8{32'h3C3C_0202}};
  localparam logic [PW-1:0] PW_C = {8{32'h1111_0303}};
  localparam logic [PW-1:0] PW_M = {8{32'h7E7E_0404}};
  localparam logic [PW-1:0] PW_X = {8{32'hDEAD_0505}};

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_lock_ctrl #(.PWD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_ctrl(cmd_ctrl), .cmd_pwd(cmd_pwd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_abort(rsp_abort),
    .erase_req(erase_req), .sec_enabled(sec_enabled), .sec_locked(sec_locked),
    .sec_frozen(sec_frozen), .sec_level_max(sec_level_max));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic en, input logic lk, input logic fz, input logic lv);
    chk(req, "flags {en,lk,fz,lv}", {28'd0, sec_enabled, sec_locked, sec_frozen, sec_level_max},
        {28'd0, en, lk, fz, lv});
  endtask

  // Sends one command, holds the result one extra cycle, then consumes it.
  task automatic send(input logic [2:0] code, input logic [15:0] ctrl, input logic [PW-1:0] pwd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_ctrl = ctrl; cmd_pwd = pwd;
    @(negedge clk);
    cmd_valid = 1'b0;
    got_abort = rsp_abort;
    got_erase = erase_req;
    chk("R2", "rsp_valid after accept", {31'd0, rsp_valid}, 32'd1);
    chk("R2", "cmd_ready while pending", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);
    chk("R2", "result held", {30'd0, rsp_valid, rsp_abort}, {30'd0, 1'b1, got_abort});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R2", "result consumed", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic expect_rsp(input string req, input logic abort_exp, input logic erase_exp);
    chk(req, "abort", {31'd0, got_abort}, {31'd0, abort_exp});
    chk(req, "erase_req", {31'd0, got_erase}, {31'd0, erase_exp});
  endtask

  task automatic pulse_hard_rst();
    @(negedge clk); hard_rst = 1'b1;
    @(negedge clk); hard_rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1", "rsp_valid/erase", {30'd0, rsp_valid, erase_req}, 32'd0);
    flags("R1", 0, 0, 0, 0);
  endtask

  task automatic t_set_and_unlock();
    send(3'd1, 16'h0000, PW_A); expect_rsp("R3", 0, 0); flags("R3", 1, 0, 0, 0);
    pulse_hard_rst(); flags("R9", 1, 1, 0, 0);
    send(3'd1, 16'h0000, PW_B); expect_rsp("R3", 1, 0); flags("R3", 1, 1, 0, 0);
    send(3'd2, 16'h0000, PW_X); expect_rsp("R10", 1, 0); flags("R10", 1, 1, 0, 0);
    send(3'd2, 16'h0000, PW_A); expect_rsp("R4", 0, 0); flags("R4", 1, 0, 0, 0);
  endtask

  task automatic t_master_level();
    send(3'd1, 16'h0001, PW_M); expect_rsp("R3", 0, 0); flags("R3", 1, 0, 0, 0);
    send(3'd1, 16'h0100, PW_A); expect_rsp("R3", 0, 0); flags("R3", 1, 0, 0, 1);
    pulse_hard_rst(); flags("R9", 1, 1, 0, 1);
    send(3'd2, 16'h0001, PW_M); expect_rsp("R4", 1, 0); flags("R4", 1, 1, 0, 1);
    send(3'd6, 16'h0001, PW_M); expect_rsp("R5", 1, 0); flags("R5", 1, 1, 0, 1);
    send(3'd2, 16'h0000, PW_A); expect_rsp("R4", 0, 0); flags("R4", 1, 0, 0, 1);
    send(3'd1, 16'h0000, PW_A); flags("R3", 1, 0, 0, 0);
    pulse_hard_rst();
    send(3'd2, 16'h0001, PW_M); expect_rsp("R4", 0, 0); flags("R4", 1, 0, 0, 0);
  endtask

  task automatic t_erase();
    pulse_hard_rst(); flags("R9", 1, 1, 0, 0);
    send(3'd4, 16'h0001, PW_M); expect_rsp("R7", 1, 0); flags("R7", 1, 1, 0, 0);
    send(3'd3, 16'h0000, '0); expect_rsp("R7", 0, 0);
    send(3'd2, 16'h0000, PW_X); expect_rsp("R10", 1, 0);
    send(3'd4, 16'h0001, PW_M); expect_rsp("R7", 1, 0); flags("R7", 1, 1, 0, 0);
    send(3'd3, 16'h0000, '0);
    send(3'd4, 16'h0001, PW_X); expect_rsp("R10", 1, 0); flags("R10", 1, 1, 0, 0);
    send(3'd3, 16'h0000, '0);
    send(3'd4, 16'h0001, PW_M); expect_rsp("R6", 0, 1); flags("R6", 0, 0, 0, 0);
    // master survives erase; then disable with master and with user
    send(3'd1, 16'h0000, PW_B); flags("R3", 1, 0, 0, 0);
    send(3'd6, 16'h0001, PW_M); expect_rsp("R5", 0, 0); flags("R5", 0, 0, 0, 0);
    send(3'd1, 16'h0000, PW_B);
    pulse_hard_rst();
    send(3'd6, 16'h0000, PW_X); expect_rsp("R10", 1, 0); flags("R10", 1, 1, 0, 0);
    send(3'd6, 16'h0000, PW_B); expect_rsp("R5", 0, 0); flags("R5", 0, 0, 0, 0);
    send(3'd2, 16'h0001, PW_M); expect_rsp("R5", 0, 0);
  endtask

  task automatic t_unknown();
    send(3'd1, 16'h0000, PW_C); flags("R11", 1, 0, 0, 0);
    send(3'd0, 16'h0000, PW_C); expect_rsp("R11", 1, 0); flags("R11", 1, 0, 0, 0);
    send(3'd7, 16'h0001, PW_M); expect_rsp("R11", 1, 0); flags("R11", 1, 0, 0, 0);
  endtask

  task automatic t_freeze();
    send(3'd5, 16'h0000, '0); expect_rsp("R8", 0, 0); flags("R8", 1, 0, 1, 0);
    send(3'd5, 16'h0000, '0); expect_rsp("R8", 0, 0); flags("R8", 1, 0, 1, 0);
    send(3'd1, 16'h0000, PW_A); expect_rsp("R8", 1, 0);
    send(3'd6, 16'h0000, PW_C); expect_rsp("R8", 1, 0); flags("R8", 1, 0, 1, 0);
    send(3'd3, 16'h0000, '0); expect_rsp("R8", 1, 0);
    send(3'd4, 16'h0001, PW_M); expect_rsp("R8", 1, 0); flags("R8", 1, 0, 1, 0);
    pulse_hard_rst(); flags("R9", 1, 1, 0, 0);
    send(3'd5, 16'h0000, '0); flags("R8", 1, 1, 1, 0);
    send(3'd2, 16'h0000, PW_C); expect_rsp("R8", 1, 0); flags("R8", 1, 1, 1, 0);
    pulse_hard_rst(); flags("R9", 1, 1, 0, 0);
    send(3'd2, 16'h0000, PW_C); expect_rsp("R4", 0, 0); flags("R4", 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_and_unlock();
    t_master_level();
    t_erase();
    t_unknown();
    t_freeze();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule